// File: doc/BRIEF.md
# Sensor-Triggered Two-Road Traffic Controller

This block runs the lamps at a crossing of a north-south road and an east-west road. North-south green is its resting condition: it stays there for as long as no car is reported on the east-west road. One detector input, raised when a car waits on the east-west side, starts a single service pass. That pass shows north-south yellow, then east-west green, then east-west yellow, and then returns to north-south green.

The machine has four phases held in a 2-bit register. Each road's 3-bit lamp field is decoded from the phase alone, so every lamp pattern comes straight from the registered state. Two rules are built into the phase order. A road never goes from green to red without a yellow cycle in between. A road can only show green while the other road shows red. Reset is synchronous and active high.

Top module: `tl_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, the lamps after that edge are `ns_lamp`=100 (green) and `ew_lamp`=001 (red).
- R2: In north-south green with `ew_wait` low at the edge, the lamps after the edge stay `ns_lamp`=100, `ew_lamp`=001.
- R3: In north-south green with `ew_wait` high at the edge, the lamps after the edge are `ns_lamp`=010 (yellow) and `ew_lamp`=001.
- R4: North-south yellow is followed on the next edge by `ns_lamp`=001, `ew_lamp`=100, whatever the value of `ew_wait`.
- R5: East-west green is followed on the next edge by `ns_lamp`=001, `ew_lamp`=010, whatever the value of `ew_wait`.
- R6: East-west yellow is followed on the next edge by `ns_lamp`=100, `ew_lamp`=001, whatever the value of `ew_wait`. A wait request that is still high then starts a new pass on the following edge.
- R7: In every cycle at least one road shows red (bit 0 set). Neither road shows green or yellow unless the other road shows red.
- R8: Outside reset, a road that shows green (100) in one cycle never shows red (001) in the next cycle.
- R9: Each lamp field is one-hot in every cycle. Bit 2 is green, bit 1 is yellow and bit 0 is red.
- R10: A reset raised in the middle of a pass, with east-west showing green or yellow, returns the lamps to `ns_lamp`=100, `ew_lamp`=001 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ew_wait | input | 1 | A car is waiting on the east-west road |
| ns_lamp | output | 3 | North-south lamps {green, yellow, red} |
| ew_lamp | output | 3 | East-west lamps {green, yellow, red} |

## Verification
Two situations are hard to reach from the ports. The first is a reset that lands while the east-west road is green. Reaching it takes a full trigger from idle, then a count of exactly two edges to arrive at east-west green, and only then the reset. The second is the back-to-back restart: `ew_wait` is held high through an entire pass, so the return to north-south green lasts exactly one cycle before yellow begins again. The directed tasks count edges to build both cases. A per-cycle monitor checks the red interlock and the yellow-before-red rule throughout every task.

// File: rtl/tl_pkg.sv
package tl_pkg;
    localparam int LAMP_W  = 3;
    localparam int NUM_DIR = 2;
    localparam int PH_W    = 2;

    // bit 1: which road is served (0 north-south, 1 east-west); bit 0: warning
    typedef enum logic [PH_W-1:0] {
        PH_NS_GO   = 2'b00,
        PH_NS_WARN = 2'b01,
        PH_EW_GO   = 2'b10,
        PH_EW_WARN = 2'b11
    } phase_e;

    typedef logic [LAMP_W-1:0] lamp_t;

    localparam lamp_t LAMP_GREEN  = 3'b100;
    localparam lamp_t LAMP_YELLOW = 3'b010;
    localparam lamp_t LAMP_RED    = 3'b001;

    typedef struct packed {
        phase_e phase;
    } seq_state_t;
endpackage

// File: rtl/tl_seq.sv
module tl_seq
    import tl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   ew_wait,
    output phase_e phase_q
);
    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_NS_GO:   if (ew_wait) st_d.phase = PH_NS_WARN;
            PH_NS_WARN: st_d.phase = PH_EW_GO;
            PH_EW_GO:   st_d.phase = PH_EW_WARN;
            PH_EW_WARN: st_d.phase = PH_NS_GO;
            default:    st_d.phase = PH_NS_GO;
        endcase
        if (rst) st_d.phase = PH_NS_GO;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign phase_q = st_q.phase;
endmodule

// File: rtl/tl_lamp_dec.sv
module tl_lamp_dec
    import tl_pkg::*;
#(
    parameter bit DIR_SEL = 1'b0
)(
    input  phase_e phase,
    output lamp_t  lamp
);
    logic served;
    logic warn;

    always_comb begin
        served = (phase[1] == DIR_SEL);
        warn   = phase[0];
        if (!served)   lamp = LAMP_RED;
        else if (warn) lamp = LAMP_YELLOW;
        else           lamp = LAMP_GREEN;
    end
endmodule

// File: rtl/tl_ctrl.sv
module tl_ctrl
    import tl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ew_wait,
    output logic [2:0] ns_lamp,
    output logic [2:0] ew_lamp
);
    phase_e phase;
    lamp_t  lamps [NUM_DIR];

    tl_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .ew_wait (ew_wait),
        .phase_q (phase)
    );

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        tl_lamp_dec #(.DIR_SEL(d[0])) u_dec (
            .phase (phase),
            .lamp  (lamps[d])
        );
    end

    assign ns_lamp = lamps[0];
    assign ew_lamp = lamps[1];
endmodule

// File: rtl/tl_ctrl_chk.sv
module tl_ctrl_chk
    import tl_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       ew_wait,
    input logic [2:0] ns_lamp,
    input logic [2:0] ew_lamp
);
    a_r1_reset_lamps: assert property (@(posedge clk)
        rst |=> (ns_lamp == LAMP_GREEN && ew_lamp == LAMP_RED));

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (ns_lamp == LAMP_GREEN && !ew_wait) |=> (ns_lamp == LAMP_GREEN && ew_lamp == LAMP_RED));

    a_r3_trigger: assert property (@(posedge clk) disable iff (rst)
        (ns_lamp == LAMP_GREEN && ew_wait) |=> (ns_lamp == LAMP_YELLOW && ew_lamp == LAMP_RED));

    a_r4_ns_warn_next: assert property (@(posedge clk) disable iff (rst)
        (ns_lamp == LAMP_YELLOW) |=> (ns_lamp == LAMP_RED && ew_lamp == LAMP_GREEN));

    a_r5_ew_go_next: assert property (@(posedge clk) disable iff (rst)
        (ew_lamp == LAMP_GREEN) |=> (ns_lamp == LAMP_RED && ew_lamp == LAMP_YELLOW));

    a_r6_ew_warn_next: assert property (@(posedge clk) disable iff (rst)
        (ew_lamp == LAMP_YELLOW) |=> (ns_lamp == LAMP_GREEN && ew_lamp == LAMP_RED));

    a_r7_interlock: assert property (@(posedge clk) disable iff (rst)
        (ns_lamp[0] || ew_lamp[0]));

    a_r8_ns_no_skip: assert property (@(posedge clk) disable iff (rst)
        (ns_lamp == LAMP_GREEN) |=> (ns_lamp != LAMP_RED));

    a_r8_ew_no_skip: assert property (@(posedge clk) disable iff (rst)
        (ew_lamp == LAMP_GREEN) |=> (ew_lamp != LAMP_RED));

    a_r9_onehot: assert property (@(posedge clk) disable iff (rst)
        ($countones(ns_lamp) == 1 && $countones(ew_lamp) == 1));

    a_r10_mid_reset: assert property (@(posedge clk)
        (rst && ew_lamp != LAMP_RED) |=> (ns_lamp == LAMP_GREEN && ew_lamp == LAMP_RED));
endmodule

bind tl_ctrl tl_ctrl_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .ew_wait (ew_wait),
    .ns_lamp (ns_lamp),
    .ew_lamp (ew_lamp)
);

// File: tb/tl_ctrl_tb.sv
module tl_ctrl_tb;
    localparam logic [2:0] GRN = 3'b100;
    localparam logic [2:0] YEL = 3'b010;
    localparam logic [2:0] RED = 3'b001;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ew_wait = 1'b0;
    logic [2:0] ns_lamp, ew_lamp;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    tl_ctrl u_dut (
        .clk     (clk),
        .rst     (rst),
        .ew_wait (ew_wait),
        .ns_lamp (ns_lamp),
        .ew_lamp (ew_lamp)
    );

    always #5 clk = ~clk;

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string req, logic [2:0] exp_ns, logic [2:0] exp_ew);
        total++;
        if (ns_lamp !== exp_ns || ew_lamp !== exp_ew) begin
            bad++;
            $display("FAIL %s: ns=%b ew=%b expected ns=%b ew=%b",
                     req, ns_lamp, ew_lamp, exp_ns, exp_ew);
        end
    endtask

    // Per-cycle monitor for R7, R8, R9
    logic [2:0] prev_ns, prev_ew;
    logic       prev_valid = 1'b0;
    always begin
        @(negedge clk);
        #2;
        if (!rst) begin
            total++;
            if (!(ns_lamp[0] || ew_lamp[0])) begin
                bad++;
                $display("FAIL R7: ns=%b ew=%b expected one road red", ns_lamp, ew_lamp);
            end
            total++;
            if ($countones(ns_lamp) != 1 || $countones(ew_lamp) != 1) begin
                bad++;
                $display("FAIL R9: ns=%b ew=%b expected one-hot fields", ns_lamp, ew_lamp);
            end
            if (prev_valid) begin
                total++;
                if ((prev_ns == GRN && ns_lamp == RED) || (prev_ew == GRN && ew_lamp == RED)) begin
                    bad++;
                    $display("FAIL R8: ns %b->%b ew %b->%b expected yellow between",
                             prev_ns, ns_lamp, prev_ew, ew_lamp);
                end
            end
            prev_ns = ns_lamp;
            prev_ew = ew_lamp;
            prev_valid = 1'b1;
        end else begin
            prev_valid = 1'b0;
        end
    end

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        ew_wait = 1'b1;
        step();
        check("R1 reset lamps", GRN, RED);
        step();
        check("R1 reset held with wait high", GRN, RED);
        rst = 1'b0;
        ew_wait = 1'b0;
    endtask

    task automatic t_idle();
        ew_wait = 1'b0;
        for (int i = 0; i < 6; i++) begin
            step();
            check("R2 idle stays north-south green", GRN, RED);
        end
    endtask

    task automatic t_single_pass();
        ew_wait = 1'b1;
        step();
        check("R3 trigger to north-south yellow", YEL, RED);
        ew_wait = 1'b0;
        step();
        check("R4 east-west green, wait low", RED, GRN);
        step();
        check("R5 east-west yellow, wait low", RED, YEL);
        step();
        check("R6 back to north-south green", GRN, RED);
        step();
        check("R2 rest after pass", GRN, RED);
    endtask

    task automatic t_held_wait();
        ew_wait = 1'b1;
        step();
        check("R3 trigger held", YEL, RED);
        step();
        check("R4 east-west green, wait high", RED, GRN);
        step();
        check("R5 east-west yellow, wait high", RED, YEL);
        step();
        check("R6 return with wait high", GRN, RED);
        step();
        check("R6 immediate restart", YEL, RED);
        ew_wait = 1'b0;
        step(); step(); step();
        check("R6 second pass return", GRN, RED);
    endtask

    task automatic t_toggle_wait();
        ew_wait = 1'b1;
        step();
        check("R3 pulse trigger", YEL, RED);
        ew_wait = 1'b0;
        step();
        check("R4 ignores wait low", RED, GRN);
        ew_wait = 1'b1;
        step();
        check("R5 ignores wait high", RED, YEL);
        ew_wait = 1'b0;
        step();
        check("R6 ignores wait low", GRN, RED);
        step();
        check("R2 no restart when wait low", GRN, RED);
    endtask

    task automatic t_mid_reset();
        ew_wait = 1'b1;
        step();
        ew_wait = 1'b0;
        step();
        check("R4 reach east-west green before reset", RED, GRN);
        rst = 1'b1;
        step();
        check("R10 reset from east-west green", GRN, RED);
        rst = 1'b0;
        ew_wait = 1'b1;
        step(); step(); step();
        check("R5 reach east-west yellow before reset", RED, YEL);
        ew_wait = 1'b0;
        rst = 1'b1;
        step();
        check("R10 reset from east-west yellow", GRN, RED);
        rst = 1'b0;
        step();
        check("R2 idle after mid reset", GRN, RED);
    endtask

    initial begin
        t_reset();
        t_idle();
        t_single_pass();
        t_held_wait();
        t_toggle_wait();
        t_mid_reset();
        t_idle();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule